// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter

This block turns parallel characters into an asynchronous serial bit stream. A producer offers a character through a valid/ready handshake. The character sits in a one-entry holding stage while the previous character is still being shifted out. The shifter sends one frame per character, in this order:

- a low start bit;
- 5 to 8 data bits, least significant bit first;
- an optional parity bit;
- a high stop period of one, one and a half, or two bit times.

Bit timing comes from a one-cycle 16x oversampling enable, `baud_tick`. The divider that produces this enable sits outside the block. A flow-control gate input decides whether a new frame may begin. A break control forces the line low. Two status outputs report when the holding stage is empty and when the transmitter is fully quiet.

The producer applies back-pressure through the handshake. A character is transferred on a rising clock edge where `in_valid` and `in_ready` are both high. After that edge `in_ready` stays low until the shifter takes the held character. The producer must then keep `in_valid` and `in_data` steady until the next transfer. A character offered while `in_ready` is low is not lost: it waits at the input. Frame settings are captured when the shifter loads a character, so they may be changed safely at any time between characters.

Top module: `uart_tx_serializer`

## Requirements
- R1: After reset, `txd` is 1, `in_ready` is 1, `hold_empty` is 1 and `shift_idle` is 1.
- R2: A transfer happens on an edge where `in_valid` and `in_ready` are both 1. From the next cycle, `in_ready` and `hold_empty` are 0 until the shifter takes the character. Both return to 1 a few cycles after the start bit begins.
- R3: The idle line is 1. A frame begins with a start bit of 0 that lasts 16 ticks. The data bits follow, least significant first, each lasting 16 ticks.
- R4: `cfg_len` selects the number of data bits: 0 selects 5, 1 selects 6, 2 selects 7 and 3 selects 8. Bits of `in_data` above the selected length are not sent.
- R5: With `cfg_par_en` = 1, a 16-tick parity bit follows the data. With `cfg_par_odd` = 0 the parity bit makes the number of ones among the data bits and the parity bit even; with 1, odd. With `cfg_par_en` = 0 no parity bit is sent.
- R6: With `cfg_stop_long` = 0 the stop period is 16 ticks. With `cfg_stop_long` = 1 it is 24 ticks when `cfg_len` = 0 and 32 ticks for any other length.
- R7: When a character is held and the gate is open as a stop period ends, the next start bit follows with no idle gap. Frames sent back to back therefore repeat every 16·(1 + data bits + parity bit) + stop ticks.
- R8: A frame starts only while `cts_gate` = 1. Closing the gate during a frame does not shorten or alter that frame.
- R9: While `cfg_break` = 1, `txd` is 0, starting one cycle after `cfg_break` rises. `txd` follows the serial stream again one cycle after `cfg_break` falls.
- R10: `shift_idle` is 1 only when no frame is in progress and no character is held. After the last frame it rises on the edge that ends its stop period.
- R11: Length, parity and stop settings are captured when a character is loaded into the shifter. Changing them during a frame does not affect that frame.
- R12: The frame advances only on cycles where `baud_tick` = 1. `txd` is registered and changes one clock cycle after the shifter changes bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle 16x oversampling enable |
| in_valid | input | 1 | Producer offers a character |
| in_data | input | 8 | Character to send, least significant bit sent first |
| in_ready | output | 1 | Holding stage can accept a character |
| cfg_len | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_stop_long | input | 1 | 1 selects the longer stop period (1.5 or 2 bits) |
| cfg_break | input | 1 | Force the serial line low |
| cts_gate | input | 1 | 1 allows a new frame to start |
| txd | output | 1 | Serial output, idle high |
| hold_empty | output | 1 | Holding stage holds no character |
| shift_idle | output | 1 | No frame in progress and nothing held |

## Verification
The handshake and status results are due one cycle after the causing edge. The bench samples them on the following falling edge. `txd` reacts to break one cycle after the control changes, so the bench checks it on the falling edge after the next rising edge.

Bit values are sampled by a decoder that counts ticks from the start bit it observed and reads each bit at its mid-point. This keeps the readings clear of the one-tick uncertainty in where the first frame begins.

Exact timing is checked with a tick on every cycle. Back-to-back frames must then fall exactly one frame length apart. `shift_idle` must rise exactly one cycle less than a frame length after the observed start.

// File: rtl/uart_txs_pkg.sv
package uart_txs_pkg;

  typedef enum logic [2:0] {
    TXS_IDLE  = 3'd0,
    TXS_START = 3'd1,
    TXS_DATA  = 3'd2,
    TXS_PAR   = 3'd3,
    TXS_STOP  = 3'd4
  } txs_state_e;

  typedef struct packed {
    logic [1:0] len_sel;
    logic       par_en;
    logic       par_odd;
    logic       stop_long;
  } txs_cfg_t;

endpackage

// File: rtl/txs_hold_stage.sv
module txs_hold_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              pop,
  output logic              hold_valid,
  output logic [DATA_W-1:0] hold_data
);

  logic accept;

  assign in_ready = !hold_valid;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
    end else if (accept) begin
      hold_valid <= 1'b1;
      hold_data  <= in_data;
    end else if (pop) begin
      hold_valid <= 1'b0;
    end
  end

  // R2
  accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (hold_valid && !in_ready));

  // R2
  pop_needs_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> hold_valid);

  // R2
  held_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_valid && !pop) |=> $stable(hold_data));

endmodule

// File: rtl/txs_shifter.sv
module txs_shifter
  import uart_txs_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              gate,
  input  txs_cfg_t          cfg,
  input  logic              hold_valid,
  input  logic [DATA_W-1:0] hold_data,
  output logic              pop,
  output logic              serial_bit,
  output logic              busy
);

  localparam int CNT_W    = $clog2(2 * TICKS_PER_BIT);
  localparam int IDX_W    = $clog2(DATA_W);
  localparam int MIN_BITS = DATA_W - 3;
  localparam logic [CNT_W-1:0] LAST_TICK  = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] STOP_ONE   = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] STOP_HALF  = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1);
  localparam logic [CNT_W-1:0] STOP_TWO   = CNT_W'(2 * TICKS_PER_BIT - 1);

  txs_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  stop_last;
  logic [IDX_W-1:0]  bit_idx;
  logic [IDX_W-1:0]  nb_last;
  logic [DATA_W-1:0] shreg;
  logic              par_en_q;
  logic              par_bit;

  logic              start_ok;
  logic              bit_end;
  logic              stop_end;
  logic [IDX_W-1:0]  new_nb_last;
  logic [CNT_W-1:0]  new_stop_last;
  logic              new_par_bit;

  function automatic logic masked_parity(input logic [DATA_W-1:0] d,
                                         input logic [IDX_W-1:0]  last);
    logic p;
    p = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (IDX_W'(i) <= last) p = p ^ d[i];
    end
    return p;
  endfunction

  assign start_ok  = hold_valid && gate;
  assign bit_end   = tick && (cnt == LAST_TICK);
  assign stop_end  = tick && (cnt == stop_last);
  assign pop       = start_ok && ((state == TXS_IDLE) || ((state == TXS_STOP) && stop_end));
  assign busy      = (state != TXS_IDLE);

  assign new_nb_last = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg.len_sel);
  assign new_par_bit = masked_parity(hold_data, new_nb_last) ^ cfg.par_odd;

  always_comb begin
    if (!cfg.stop_long)          new_stop_last = STOP_ONE;
    else if (cfg.len_sel == 2'd0) new_stop_last = STOP_HALF;
    else                         new_stop_last = STOP_TWO;
  end

  always_comb begin
    case (state)
      TXS_START: serial_bit = 1'b0;
      TXS_DATA:  serial_bit = shreg[0];
      TXS_PAR:   serial_bit = par_bit;
      default:   serial_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= TXS_IDLE;
      cnt       <= '0;
      stop_last <= STOP_ONE;
      bit_idx   <= '0;
      nb_last   <= '0;
      shreg     <= '0;
      par_en_q  <= 1'b0;
      par_bit   <= 1'b0;
    end else if (pop) begin
      state     <= TXS_START;
      cnt       <= '0;
      bit_idx   <= '0;
      shreg     <= hold_data;
      nb_last   <= new_nb_last;
      stop_last <= new_stop_last;
      par_en_q  <= cfg.par_en;
      par_bit   <= new_par_bit;
    end else begin
      case (state)
        TXS_IDLE: begin
          cnt <= '0;
        end
        TXS_START: begin
          if (bit_end) begin
            cnt     <= '0;
            bit_idx <= '0;
            state   <= TXS_DATA;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        TXS_DATA: begin
          if (bit_end) begin
            cnt   <= '0;
            shreg <= shreg >> 1;
            if (bit_idx == nb_last) begin
              state <= par_en_q ? TXS_PAR : TXS_STOP;
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        TXS_PAR: begin
          if (bit_end) begin
            cnt   <= '0;
            state <= TXS_STOP;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        TXS_STOP: begin
          if (stop_end) begin
            cnt   <= '0;
            state <= TXS_IDLE;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= TXS_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  // R3
  bit_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TXS_DATA) |-> (bit_idx <= nb_last));

  // R6
  stop_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TXS_STOP) |-> (cnt <= stop_last));

  // R3
  bit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state != TXS_STOP) && (state != TXS_IDLE)) |-> (cnt <= LAST_TICK));

  // R8
  gate_holds_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == TXS_IDLE) && !gate) |=> (state == TXS_IDLE));

  // R7
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == TXS_STOP) && stop_end && hold_valid && gate) |=> (state == TXS_START));

  // R12
  tick_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && (state != TXS_IDLE)) |=> $stable(state));

endmodule

// File: rtl/txs_line_driver.sv
module txs_line_driver (
  input  logic clk,
  input  logic rst_n,
  input  logic serial_bit,
  input  logic brk,
  output logic txd
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txd <= 1'b1;
    else        txd <= brk ? 1'b0 : serial_bit;
  end

  // R9
  break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> !txd);

  // R12
  line_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !brk |=> (txd == $past(serial_bit)));

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
  import uart_txs_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop_long,
  input  logic              cfg_break,
  input  logic              cts_gate,
  output logic              txd,
  output logic              hold_empty,
  output logic              shift_idle
);

  logic              hold_valid;
  logic [DATA_W-1:0] hold_data;
  logic              pop;
  logic              serial_bit;
  logic              busy;
  txs_cfg_t          cfg;

  assign cfg.len_sel   = cfg_len;
  assign cfg.par_en    = cfg_par_en;
  assign cfg.par_odd   = cfg_par_odd;
  assign cfg.stop_long = cfg_stop_long;

  txs_hold_stage #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .pop       (pop),
    .hold_valid(hold_valid),
    .hold_data (hold_data)
  );

  txs_shifter #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .gate      (cts_gate),
    .cfg       (cfg),
    .hold_valid(hold_valid),
    .hold_data (hold_data),
    .pop       (pop),
    .serial_bit(serial_bit),
    .busy      (busy)
  );

  txs_line_driver u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .serial_bit(serial_bit),
    .brk       (cfg_break),
    .txd       (txd)
  );

  assign hold_empty = !hold_valid;
  assign shift_idle = !busy && !hold_valid;

  // R10
  quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_idle && !cfg_break && $past(shift_idle) && !$past(cfg_break)) |-> txd);

endmodule

// File: tb/tb_uart_tx_serializer.sv
`timescale 1ns/1ps
module tb_uart_tx_serializer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_ready;
  logic [1:0] cfg_len;
  logic       cfg_par_en, cfg_par_odd, cfg_stop_long, cfg_break, cts_gate;
  logic       txd, hold_empty, shift_idle;

  always #2.5 clk = ~clk;

  uart_tx_serializer dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop_long(cfg_stop_long), .cfg_break(cfg_break), .cts_gate(cts_gate),
    .txd(txd), .hold_empty(hold_empty), .shift_idle(shift_idle)
  );

  typedef struct packed {
    logic [7:0] d;
    logic [3:0] n;
    logic       pe;
    logic       po;
    logic [5:0] st;
  } exp_t;

  exp_t expq[$];
  int   falls[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   cyc      = 0;
  int   tick_mode = 0;
  bit   gate_rand = 0;
  bit   dec_en   = 1;
  bit   done     = 0;
  int   dstate   = 0;
  int   pos      = 0;
  int   nb       = 0;
  int   rise_cyc = -1;
  bit   prev_idle = 1;
  exp_t cur;
  logic [7:0] got_d;
  logic       got_p;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int stop_ticks(input logic [1:0] len, input logic sl);
    if (!sl) return 16;
    return (len == 2'd0) ? 24 : 32;
  endfunction

  function automatic int frame_ticks(input logic [1:0] len, input logic pe, input logic sl);
    return 16 * (1 + 5 + int'(len) + int'(pe)) + stop_ticks(len, sl);
  endfunction

  function automatic logic [7:0] mask_bits(input logic [7:0] d, input int n);
    return d & 8'((1 << n) - 1);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // tick generator: 0 = every cycle, 1 = random, 2 = frozen
  initial begin
    baud_tick = 1'b0;
    forever begin
      @(posedge clk); #1;
      case (tick_mode)
        0:       baud_tick = 1'b1;
        1:       baud_tick = ($urandom % 3) == 0;
        default: baud_tick = 1'b0;
      endcase
      if (gate_rand && ($urandom % 97) == 0) cts_gate = ~cts_gate;
    end
  end

  // serial decoder
  always @(negedge clk) begin
    if (rst_n && shift_idle && !prev_idle) rise_cyc = cyc;
    prev_idle = shift_idle;
    if (!rst_n || !dec_en) begin
      dstate = 0;
    end else if (dstate == 0) begin
      if (txd == 1'b0) begin
        if (expq.size() == 0) begin
          chk(0, "R8", "start bit with no character pending", 0, 1);
          dstate = 2;
        end else begin
          cur = expq.pop_front();
          pos = 0; got_d = '0; got_p = 1'b0;
          nb = 1 + int'(cur.n) + int'(cur.pe);
          falls.push_back(cyc);
          dstate = 1;
        end
      end
    end else if (dstate == 2) begin
      if (txd == 1'b1) dstate = 0;
    end else if (baud_tick) begin
      pos++;
      if (pos == 8) chk(txd == 1'b0, "R3", "start bit level", txd, 0);
      for (int k = 1; k < nb; k++) begin
        if (pos == 16 * k + 8) begin
          if (k <= int'(cur.n)) got_d[k-1] = txd;
          else                  got_p = txd;
        end
      end
      if (pos == 16 * nb + 8) begin
        chk(txd == 1'b1, "R6", "stop level at start of stop", txd, 1);
        chk(shift_idle == 1'b0, "R10", "shift_idle during frame", shift_idle, 0);
      end
      if (pos == 16 * nb + int'(cur.st) - 3) begin
        chk(txd == 1'b1, "R6", "stop level near end of stop", txd, 1);
        chk(got_d == mask_bits(cur.d, int'(cur.n)), "R4",
            "received data bits", got_d, mask_bits(cur.d, int'(cur.n)));
        if (cur.pe)
          chk(got_p == ((^mask_bits(cur.d, int'(cur.n))) ^ cur.po), "R5",
              "parity bit", got_p, (^mask_bits(cur.d, int'(cur.n))) ^ cur.po);
        dstate = 0;
      end
    end
  end

  task automatic send(input logic [7:0] d);
    exp_t e;
    in_valid = 1'b1;
    in_data  = d;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    e.d = d; e.n = 4'(5 + int'(cfg_len)); e.pe = cfg_par_en; e.po = cfg_par_odd;
    e.st = 6'(stop_ticks(cfg_len, cfg_stop_long));
    expq.push_back(e);
    @(posedge clk); #1;
    in_valid = 1'b0;
    in_data  = $urandom;
  endtask

  task automatic wait_quiet();
    do @(negedge clk);
    while (!(dstate == 0 && expq.size() == 0 && shift_idle));
    repeat (4) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] l, input logic pe, input logic po, input logic sl);
    @(posedge clk); #1;
    cfg_len = l; cfg_par_en = pe; cfg_par_odd = po; cfg_stop_long = sl;
  endtask

  task automatic burst_timing(input logic [1:0] l, input logic pe, input logic po,
                              input logic sl, input string req);
    int f;
    set_cfg(l, pe, po, sl);
    falls.delete();
    f = frame_ticks(l, pe, sl);
    for (int i = 0; i < 3; i++) send(8'($urandom));
    wait_quiet();
    chk(falls.size() == 3, req, "frames seen in burst", falls.size(), 3);
    if (falls.size() == 3) begin
      chk(falls[1] - falls[0] == f, req, "first frame period", falls[1] - falls[0], f);
      chk(falls[2] - falls[1] == f, "R7", "back-to-back period", falls[2] - falls[1], f);
      chk(rise_cyc - falls[2] == f - 1, "R10", "shift_idle rise delay",
          rise_cyc - falls[2], f - 1);
    end
  endtask

  initial begin
    int ref_txd;
    int f;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_stop_long = 1'b0;
    cfg_break = 1'b0; cts_gate = 1'b1;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1", "txd after reset", txd, 1);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(hold_empty == 1'b1, "R1", "hold_empty after reset", hold_empty, 1);
    chk(shift_idle == 1'b1, "R1", "shift_idle after reset", shift_idle, 1);

    // R2 / R8: gate closed holds the character
    @(posedge clk); #1 cts_gate = 1'b0;
    send(8'hA5);
    chk(in_ready == 1'b0, "R2", "in_ready after transfer", in_ready, 0);
    chk(hold_empty == 1'b0, "R2", "hold_empty after transfer", hold_empty, 0);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) begin
        chk(0, "R8", "line moved with gate closed", txd, 1);
        break;
      end
    end
    chk(shift_idle == 1'b0, "R10", "shift_idle with held char", shift_idle, 0);
    @(posedge clk); #1 cts_gate = 1'b1;
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1, "R2", "in_ready after shifter load", in_ready, 1);
    chk(hold_empty == 1'b1, "R2", "hold_empty after shifter load", hold_empty, 1);
    repeat (20) @(posedge clk);
    #1 cts_gate = 1'b0;   // R8: closing mid-frame must not cut it
    wait_quiet();
    @(posedge clk); #1 cts_gate = 1'b1;

    // R6 / R7 / R10 exact timing with a tick each cycle
    tick_mode = 0;
    burst_timing(2'd0, 1'b0, 1'b0, 1'b1, "R6");
    burst_timing(2'd3, 1'b1, 1'b0, 1'b1, "R6");
    burst_timing(2'd1, 1'b0, 1'b0, 1'b0, "R6");
    burst_timing(2'd2, 1'b1, 1'b1, 1'b0, "R5");

    // R11: settings changed mid-frame do not affect it
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    falls.delete();
    send(8'h3C);
    do @(negedge clk); while (falls.size() == 0);
    set_cfg(2'd0, 1'b1, 1'b1, 1'b1);
    wait_quiet();
    f = frame_ticks(2'd3, 1'b0, 1'b0);
    chk(rise_cyc - falls[0] == f - 1, "R11", "frame length after mid-frame change",
        rise_cyc - falls[0], f - 1);

    // R12: frozen ticks freeze the line
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    falls.delete();
    send(8'h0F);
    do @(negedge clk); while (falls.size() == 0);
    repeat (20) @(negedge clk);
    @(posedge clk); #1 tick_mode = 2; baud_tick = 1'b0;
    @(negedge clk); ref_txd = txd;
    begin
      bit moved;
      moved = 0;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (txd !== ref_txd[0]) moved = 1;
      end
      chk(!moved, "R12", "line change without ticks", moved, 0);
    end
    @(posedge clk); #1 tick_mode = 0;
    wait_quiet();

    // R9: break forces the line low
    dec_en = 0;
    @(posedge clk); #1 cfg_break = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(txd == 1'b0, "R9", "txd one cycle after break", txd, 0);
    repeat (20) @(negedge clk);
    chk(txd == 1'b0, "R9", "txd held during break", txd, 0);
    @(posedge clk); #1 cfg_break = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(txd == 1'b1, "R9", "txd after break release", txd, 1);
    dec_en = 1;

    // R3 / R4 / R5 / R8 random characters, random ticks, toggling gate
    tick_mode = 1;
    gate_rand = 1;
    for (int g = 0; g < 5; g++) begin
      set_cfg(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      for (int i = 0; i < 5; i++) send(8'($urandom));
      wait_quiet();
    end
    gate_rand = 0;
    cts_gate = 1'b1;

    // directed corner: 5-bit odd parity, upper bits set
    tick_mode = 0;
    set_cfg(2'd0, 1'b1, 1'b1, 1'b1);
    send(8'hE0);
    send(8'hFF);
    wait_quiet();

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired (R1..): actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule